// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block turns one external interrupt request pin into an interrupt for the processor. The pin passes through a synchronizer chain. The block then looks for a transition toward a programmable active level. In one mode it also treats a steady active level as an event. A detected event sets a sticky flag. The flag drives the interrupt request output when interrupts are enabled. Software clears the flag by writing a one to an acknowledge bit that always reads back as zero.

Software sets the block up through a single 8-bit control and status register on a simple synchronous bus. The bus has a register select, a read strobe, a write strobe, and separate write and read data. The block also drives two pad controls, a pull-up enable and a pull-down enable. Which one is active follows the chosen polarity, so the pad's resting level is always the inactive one.

Top module: `extirq_pin_ctrl`

## Requirements
- R1: After reset the register reads 0x00, and the interrupt output and both pull enables are low.
- R2: The register bit positions are: bit 5 polarity (1 = rising/high), bit 4 pin enable, bit 3 event flag (read-only), bit 2 acknowledge (write-only), bit 1 interrupt enable, bit 0 mode (1 = edge and level). Bits 5, 4, 1 and 0 read back what was written. Bits 7, 6 and 2 always read 0, and writes to bits 7, 6 and 3 have no effect.
- R3: In edge-only mode, a pin transition into the active level sets the flag, and a transition out of it does not. The flag is visible two clock edges after the edge that first samples the new pin value.
- R4: In edge-and-level mode, an active pin level sets the flag. An acknowledge written while the level is still active leaves the flag set.
- R5: In edge-only mode, an acknowledge clears the flag even while the pin stays at its active level.
- R6: With the pin enable at 0, no event sets the flag. Turning the enable on while the pin already sits at its active level does not set the flag in edge-only mode.
- R7: The pull-down enable is high exactly when the pin is enabled with rising polarity. The pull-up enable is high exactly when the pin is enabled with falling polarity. The two are never high together.
- R8: The interrupt output equals the flag ANDed with the interrupt enable. The flag still sets while the interrupt enable is 0.
- R9: If a qualifying edge and an acknowledge write arrive in the same cycle, the flag stays set.
- R10: A write that changes the polarity or mode does not by itself set the flag in edge-only mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 1 | Register select |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, zero when not reading |
| pinIn | input | 1 | External interrupt request pin |
| irqOut | output | 1 | Interrupt request to the processor |
| pullUpEn | output | 1 | Pad pull-up enable |
| pullDnEn | output | 1 | Pad pull-down enable |

## Verification
The bench builds the block with the default two-stage synchronizer. This gives a fixed, short latency from pin to flag. That fixed latency lets the bench place an acknowledge write in exactly the cycle where a fresh edge is detected, which is the collision case of R9. The same timing lets it place a polarity flip right against an already active pin, which is the false-edge case of R10. A vector table sweeps polarity, mode, enable and interrupt gating over pin transitions. Directed cases then cover the reset value, the reserved and read-only bits, held levels against acknowledges, and enabling the pin onto an active level.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_POL  = 5;
  localparam int BIT_EN   = 4;
  localparam int BIT_FLAG = 3;
  localparam int BIT_ACK  = 2;
  localparam int BIT_IE   = 1;
  localparam int BIT_MODE = 0;

  typedef struct packed {
    logic ackPulse;   // acknowledge written this cycle
    logic cfgSettle;  // polarity/mode changed last cycle: mask edges
    logic pinEn;
    logic polHigh;
    logic levelMode;
  } pinCtl_t;
endpackage

// File: rtl/extirq_detect.sv
module extirq_detect
  import extirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    pinRaw,
  input  pinCtl_t ctl,
  output logic    flagQ
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  logic pinSync, activeNow, prevActive, edgeHit, levelHit, setEvent;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= pinRaw;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[i] <= 1'b0;
          else       syncQ[i] <= syncQ[i-1];
      end
    end
  endgenerate

  assign pinSync   = syncQ[LAST];
  assign activeNow = ctl.polHigh ? pinSync : ~pinSync;
  assign edgeHit   = activeNow & ~prevActive & ~ctl.cfgSettle;
  assign levelHit  = ctl.levelMode & activeNow;
  assign setEvent  = ctl.pinEn & (edgeHit | levelHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevActive <= 1'b0;
      flagQ      <= 1'b0;
    end else begin
      prevActive <= activeNow;
      flagQ      <= setEvent | (flagQ & ~ctl.ackPulse);
    end
  end

  // R6: the flag can only rise while the pin function was enabled
  assert_rise_needs_en_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> $past(ctl.pinEn));

  // R5: edge-only acknowledge with no fresh edge clears the flag
  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.ackPulse && !ctl.levelMode && !edgeHit) |=> !flagQ);

  // R9: an edge colliding with an acknowledge keeps the flag
  assert_edge_beats_ack_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.ackPulse && edgeHit && ctl.pinEn) |=> flagQ);

  // R10: a configuration change alone does not raise the flag in edge mode
  assert_cfg_no_event_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.cfgSettle && !ctl.levelMode) |=> !$rose(flagQ));
endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
  import extirq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             flagQ,
  output pinCtl_t          ctl,
  output logic [REG_W-1:0] rdData,
  output logic             irqOut,
  output logic             pullUpEn,
  output logic             pullDnEn
);
  logic wrHit, polHigh, pinEn, intEn, levelMode, cfgSettle;
  logic [REG_W-1:0] regView;

  assign wrHit = regSel & wrEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polHigh   <= 1'b0;
      pinEn     <= 1'b0;
      intEn     <= 1'b0;
      levelMode <= 1'b0;
      cfgSettle <= 1'b0;
    end else begin
      cfgSettle <= wrHit & ((wrData[BIT_POL] ^ polHigh) | (wrData[BIT_MODE] ^ levelMode));
      if (wrHit) begin
        polHigh   <= wrData[BIT_POL];
        pinEn     <= wrData[BIT_EN];
        intEn     <= wrData[BIT_IE];
        levelMode <= wrData[BIT_MODE];
      end
    end
  end

  always_comb begin
    regView           = '0;
    regView[BIT_POL]  = polHigh;
    regView[BIT_EN]   = pinEn;
    regView[BIT_FLAG] = flagQ;
    regView[BIT_IE]   = intEn;
    regView[BIT_MODE] = levelMode;
  end

  assign rdData = (regSel & rdEn) ? regView : '0;

  assign ctl.ackPulse  = wrHit & wrData[BIT_ACK];
  assign ctl.cfgSettle = cfgSettle;
  assign ctl.pinEn     = pinEn;
  assign ctl.polHigh   = polHigh;
  assign ctl.levelMode = levelMode;

  assign irqOut   = flagQ & intEn;
  assign pullDnEn = pinEn & polHigh;
  assign pullUpEn = pinEn & ~polHigh;

  // R7: pad pulls are mutually exclusive
  assert_pull_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(pullUpEn && pullDnEn));

  // R2: reserved and acknowledge positions read zero
  assert_resv_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && rdEn) |-> (rdData[7:6] == 2'b00 && rdData[BIT_ACK] == 1'b0));
endmodule

// File: rtl/extirq_pin_ctrl.sv
module extirq_pin_ctrl
  import extirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regSel,
  input  logic       rdEn,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       pinIn,
  output logic       irqOut,
  output logic       pullUpEn,
  output logic       pullDnEn
);
  pinCtl_t ctl;
  logic    flagQ;

  extirq_regs u_regs (
    .clk(clk), .rstN(rstN), .regSel(regSel), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .flagQ(flagQ), .ctl(ctl), .rdData(rdData),
    .irqOut(irqOut), .pullUpEn(pullUpEn), .pullDnEn(pullDnEn)
  );

  extirq_detect #(.SYNC_STAGES(SYNC_STAGES)) u_detect (
    .clk(clk), .rstN(rstN), .pinRaw(pinIn), .ctl(ctl), .flagQ(flagQ)
  );
endmodule

// File: tb/extirq_pin_ctrl_tb.sv
module extirq_pin_ctrl_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regSel = 1'b0, rdEn = 1'b0, wrEn = 1'b0, pinIn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic irqOut, pullUpEn, pullDnEn;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  extirq_pin_ctrl u_dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .pinIn(pinIn), .irqOut(irqOut),
    .pullUpEn(pullUpEn), .pullDnEn(pullDnEn)
  );

  typedef struct packed {
    logic [7:0] cfg;
    logic       p0;
    logic       p1;
    logic       expFlag;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h32, 1'b0, 1'b1, 1'b1},  // R3 rising edge sets
    '{8'h32, 1'b1, 1'b0, 1'b0},  // R3 falling ignored in rising mode
    '{8'h12, 1'b1, 1'b0, 1'b1},  // R3 falling edge sets
    '{8'h12, 1'b0, 1'b1, 1'b0},  // R3 rising ignored in falling mode
    '{8'h30, 1'b0, 1'b1, 1'b1},  // R8 flag sets with irq disabled
    '{8'h22, 1'b0, 1'b1, 1'b0},  // R6 disabled pin
    '{8'h33, 1'b0, 1'b1, 1'b1},  // R4 high level
    '{8'h13, 1'b1, 1'b0, 1'b1},  // R4 low level
    '{8'h33, 1'b1, 1'b0, 1'b1},  // R4 ack during active level keeps flag
    '{8'h32, 1'b0, 1'b0, 1'b0}   // R3 no transition
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] d);
    @(negedge clk);
    regSel = 1'b1; wrEn = 1'b1; wrData = d;
    @(negedge clk);
    regSel = 1'b0; wrEn = 1'b0; wrData = 8'h00;
  endtask

  task automatic rdReg(output logic [7:0] d);
    @(negedge clk);
    regSel = 1'b1; rdEn = 1'b1;
    #1 d = rdData;
    regSel = 1'b0; rdEn = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [7:0] r;
    waitCyc(2);
    rstN = 1'b1;
    waitCyc(2);

    // R1 reset state
    rdReg(r);
    chk("R1 reg", r, 8'h00);
    chk("R1 outs", {5'b0, irqOut, pullUpEn, pullDnEn}, 8'h00);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [7:0] c;
      c = VECS[i].cfg;
      wrReg(c | 8'h04);
      pinIn = VECS[i].p0;
      waitCyc(6);
      wrReg(c | 8'h04);
      waitCyc(2);
      pinIn = VECS[i].p1;
      waitCyc(6);
      rdReg(r);
      chk($sformatf("R3/R4/R8 vec%0d flag", i), {7'b0, r[3]}, {7'b0, VECS[i].expFlag});
      chk($sformatf("R8 vec%0d irq", i), {7'b0, irqOut}, {7'b0, VECS[i].expFlag & c[1]});
      chk($sformatf("R7 vec%0d pulls", i), {6'b0, pullUpEn, pullDnEn},
          {6'b0, c[4] & ~c[5], c[4] & c[5]});
    end

    // R2 reserved / write-only bits
    pinIn = 1'b0;
    wrReg(8'h04);
    waitCyc(4);
    wrReg(8'hFF);
    waitCyc(4);
    rdReg(r);
    chk("R2 readback", r, 8'h33);
    wrReg(8'h08);
    waitCyc(4);
    rdReg(r);
    chk("R2 flag not writable", r, 8'h00);

    // R5 edge mode ack clears while pin held active
    wrReg(8'h36);
    waitCyc(4);
    pinIn = 1'b1;
    waitCyc(5);
    rdReg(r);
    chk("R5 set", r, 8'h3A);
    wrReg(8'h36);
    waitCyc(2);
    rdReg(r);
    chk("R5 cleared", r, 8'h32);
    chk("R5 irq", {7'b0, irqOut}, 8'h00);

    // R9 edge and ack in the same cycle
    pinIn = 1'b0;
    waitCyc(5);
    wrReg(8'h36);
    waitCyc(2);
    @(negedge clk); pinIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    regSel = 1'b1; wrEn = 1'b1; wrData = 8'h36;
    @(negedge clk);
    regSel = 1'b0; wrEn = 1'b0; wrData = 8'h00;
    waitCyc(1);
    rdReg(r);
    chk("R9 flag kept", r, 8'h3A);

    // R10 polarity flip onto an active pin
    wrReg(8'h16);
    pinIn = 1'b1;
    waitCyc(5);
    wrReg(8'h16);
    waitCyc(2);
    wrReg(8'h32);
    waitCyc(5);
    rdReg(r);
    chk("R10 no flag", r, 8'h32);

    // R6 enabling onto an active level
    wrReg(8'h24);
    waitCyc(5);
    wrReg(8'h30);
    waitCyc(5);
    rdReg(r);
    chk("R6 enable no flag", r, 8'h30);

    summary();
  end
endmodule